// File: doc/BRIEF.md
# Burst-mode light-load controller

This block supervises a switching power controller at light load. It watches an 8-bit code that stands for the error-amplifier output. While normal switching runs, a code that drops below the burst threshold less a hysteresis margin stops switching. The block then enters a low-power wait with the power switch held off.

While in burst, a period timer wakes the block on a fixed cycle count and requests one probe pulse of fixed length. After the probe ends, the block waits a fixed settle delay so the error amplifier can respond to the probe. It then samples the code once. If the code is above a separate lower threshold, normal switching resumes. Otherwise the block returns to the low-power wait until the next period, which is measured from the start of the previous probe.

The peak current of the probe and the error amplifier itself lie outside this block. The three thresholds are run-time inputs. The period, probe length and settle delay are parameters.

Top module: `burst_ctl`

## Requirements
- R1: During and after reset, with no input activity, `sw_en_o`=1, `probe_o`=0 and `lp_o`=0.
- R2: While switching, the block leaves switching in the cycle after a clock edge at which `comp_code_i + hyst_code_i < thr_code_i`. The sum is taken in 9 bits so it cannot wrap. At equality, switching continues.
- R3: In burst, `sw_en_o` is 0. `lp_o` is 1 during every waiting cycle. At most one of the three outputs is high in any cycle.
- R4: The first probe starts exactly PERIOD cycles after the first low-power cycle begins. While the block stays in burst, consecutive probes start exactly PERIOD cycles apart.
- R5: `probe_o` stays high for exactly PROBE_LEN cycles. It is followed by exactly SETTLE_LEN cycles in which all three outputs are low.
- R6: The code is sampled at the clock edge that ends the last settle cycle. If `comp_code_i > low_code_i` (strictly greater) at that edge, `sw_en_o` is high from the next cycle on.
- R7: If instead `comp_code_i <= low_code_i` at that edge, `lp_o` returns high in the next cycle and the block waits for the next period.
- R8: Values of `comp_code_i` during the low-power wait, during the probe and during the settle cycles before the sampling edge have no effect on the outputs.
- R9: The thresholds are read live at every decision. A hysteresis larger than the threshold prevents entry for every code value, including zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| comp_code_i | input | CW | Digitized error-amplifier output |
| thr_code_i | input | CW | Burst threshold code |
| hyst_code_i | input | CW | Hysteresis below the threshold for entry |
| low_code_i | input | CW | Lower level the post-probe code must exceed to resume |
| sw_en_o | output | 1 | Normal switching enabled |
| probe_o | output | 1 | Probe pulse request |
| lp_o | output | 1 | Low-power wait flag |

## Verification
The assertions check several rules on every cycle: that the outputs exclude one another, the entry rule and its equality boundary, and the exact gap between probe starts and the probe width, both counted in the checker. They also tie every resume or return to sleep to the code sampled one edge earlier. Only the bench scenarios show that stray high codes during the wait, the probe or the settle window are ignored. They also show the settle length itself, the non-wrapping sum when the hysteresis exceeds the threshold, and full burst sequences against a timestamp-based reference model.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_IDLE   = 2'd1,
    ST_PROBE  = 2'd2,
    ST_SETTLE = 2'd3
  } burst_st_e;
endpackage

// File: rtl/burst_cmp.sv
module burst_cmp #(
  parameter int CW = 8
) (
  input  logic [CW-1:0] comp_code_i,
  input  logic [CW-1:0] thr_code_i,
  input  logic [CW-1:0] hyst_code_i,
  input  logic [CW-1:0] low_code_i,
  output logic          enter_o,
  output logic          wake_o
);
  localparam int SW = CW + 1;

  logic [SW-1:0] sum_w;
  logic [SW-1:0] thr_w;

  // widened sum: hysteresis above threshold never wraps
  assign sum_w   = {1'b0, comp_code_i} + {1'b0, hyst_code_i};
  assign thr_w   = {1'b0, thr_code_i};
  assign enter_o = sum_w < thr_w;
  assign wake_o  = comp_code_i > low_code_i;
endmodule

// File: rtl/burst_tmr.sv
module burst_tmr #(
  parameter int PERIOD     = 62500,
  parameter int PROBE_LEN  = 4,
  parameter int SETTLE_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic clr_i,
  output logic idle_done_o,
  output logic probe_done_o,
  output logic settle_done_o
);
  localparam int TW        = $clog2(PERIOD + 1);
  localparam int IDLE_LAST = PERIOD - 1;
  localparam int PRB_LAST  = PROBE_LEN - 1;
  localparam int STL_LAST  = PROBE_LEN + SETTLE_LEN - 1;

  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tmr_q <= '0;
    else if (hold_i || clr_i)   tmr_q <= '0;
    else                        tmr_q <= tmr_q + 1'b1;
  end

  assign idle_done_o   = tmr_q == TW'(IDLE_LAST);
  assign probe_done_o  = tmr_q == TW'(PRB_LAST);
  assign settle_done_o = tmr_q == TW'(STL_LAST);
endmodule

// File: rtl/burst_fsm.sv
module burst_fsm
  import burst_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_i,
  input  logic wake_i,
  input  logic idle_done_i,
  input  logic probe_done_i,
  input  logic settle_done_i,
  output logic tmr_hold_o,
  output logic tmr_clr_o,
  output logic sw_en_o,
  output logic probe_o,
  output logic lp_o
);
  burst_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:    if (enter_i)       st_d = ST_IDLE;
      ST_IDLE:   if (idle_done_i)   st_d = ST_PROBE;
      ST_PROBE:  if (probe_done_i)  st_d = ST_SETTLE;
      ST_SETTLE: if (settle_done_i) st_d = wake_i ? ST_RUN : ST_IDLE;
      default:                      st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_RUN;
    else         st_q <= st_d;
  end

  // timer parked while switching, restarted at each probe start
  assign tmr_hold_o = st_q == ST_RUN;
  assign tmr_clr_o  = (st_q == ST_IDLE) && idle_done_i;

  assign sw_en_o = st_q == ST_RUN;
  assign probe_o = st_q == ST_PROBE;
  assign lp_o    = st_q == ST_IDLE;
endmodule

// File: rtl/burst_ctl.sv
module burst_ctl #(
  parameter int CW         = 8,
  parameter int PERIOD     = 62500,
  parameter int PROBE_LEN  = 4,
  parameter int SETTLE_LEN = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] comp_code_i,
  input  logic [CW-1:0] thr_code_i,
  input  logic [CW-1:0] hyst_code_i,
  input  logic [CW-1:0] low_code_i,
  output logic          sw_en_o,
  output logic          probe_o,
  output logic          lp_o
);
  logic enter_w, wake_w;
  logic idle_done_w, probe_done_w, settle_done_w;
  logic tmr_hold_w, tmr_clr_w;

  burst_cmp #(.CW(CW)) u_cmp (
    .comp_code_i (comp_code_i),
    .thr_code_i  (thr_code_i),
    .hyst_code_i (hyst_code_i),
    .low_code_i  (low_code_i),
    .enter_o     (enter_w),
    .wake_o      (wake_w)
  );

  burst_tmr #(
    .PERIOD     (PERIOD),
    .PROBE_LEN  (PROBE_LEN),
    .SETTLE_LEN (SETTLE_LEN)
  ) u_tmr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .hold_i        (tmr_hold_w),
    .clr_i         (tmr_clr_w),
    .idle_done_o   (idle_done_w),
    .probe_done_o  (probe_done_w),
    .settle_done_o (settle_done_w)
  );

  burst_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .enter_i       (enter_w),
    .wake_i        (wake_w),
    .idle_done_i   (idle_done_w),
    .probe_done_i  (probe_done_w),
    .settle_done_i (settle_done_w),
    .tmr_hold_o    (tmr_hold_w),
    .tmr_clr_o     (tmr_clr_w),
    .sw_en_o       (sw_en_o),
    .probe_o       (probe_o),
    .lp_o          (lp_o)
  );
endmodule

// File: rtl/burst_ctl_chk.sv
module burst_ctl_chk #(
  parameter int CW         = 8,
  parameter int PERIOD     = 62500,
  parameter int PROBE_LEN  = 4,
  parameter int SETTLE_LEN = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [CW-1:0] comp_code_i,
  input logic [CW-1:0] thr_code_i,
  input logic [CW-1:0] hyst_code_i,
  input logic [CW-1:0] low_code_i,
  input logic          sw_en_o,
  input logic          probe_o,
  input logic          lp_o
);
  logic        probe_q;
  logic        probe_rise;
  logic [31:0] gap_q;
  logic [31:0] pw_q;
  logic        below_w;

  initial begin
    AST_PARAM_OK: assert (PROBE_LEN >= 1 && SETTLE_LEN >= 1 &&
                          PERIOD > PROBE_LEN + SETTLE_LEN); // R4
  end

  assign below_w    = ({1'b0, comp_code_i} + {1'b0, hyst_code_i}) < {1'b0, thr_code_i};
  assign probe_rise = probe_o && !probe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      probe_q <= 1'b0;
      gap_q   <= '0;
      pw_q    <= '0;
    end else begin
      probe_q <= probe_o;
      if (sw_en_o)         gap_q <= '0;
      else if (probe_rise) gap_q <= 32'd1;
      else                 gap_q <= gap_q + 32'd1;
      pw_q <= probe_o ? pw_q + 32'd1 : '0;
    end
  end

  AST_ONE_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sw_en_o, probe_o, lp_o})); // R3

  AST_ENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_en_o && below_w |=> !sw_en_o && lp_o); // R2

  AST_HOLD_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_en_o && !below_w |=> sw_en_o); // R2

  AST_PROBE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    probe_rise |-> gap_q == 32'(PERIOD)); // R4

  AST_PROBE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(probe_o) |-> pw_q == 32'(PROBE_LEN)); // R5

  AST_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_en_o) |-> $past(comp_code_i) > $past(low_code_i)); // R6

  AST_RESUME_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_en_o) |-> !$past(lp_o) && !$past(probe_o)); // R6

  AST_STAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lp_o) && !$past(sw_en_o) |-> $past(comp_code_i) <= $past(low_code_i)); // R7
endmodule

bind burst_ctl burst_ctl_chk #(
  .CW(CW), .PERIOD(PERIOD), .PROBE_LEN(PROBE_LEN), .SETTLE_LEN(SETTLE_LEN)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .comp_code_i (comp_code_i),
  .thr_code_i  (thr_code_i),
  .hyst_code_i (hyst_code_i),
  .low_code_i  (low_code_i),
  .sw_en_o     (sw_en_o),
  .probe_o     (probe_o),
  .lp_o        (lp_o)
);

// File: tb/burst_ctl_tb.sv
module burst_ctl_tb;
  localparam int CW = 8;
  localparam int P  = 40;
  localparam int L  = 3;
  localparam int S  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] comp = 8'd150;
  logic [CW-1:0] thr  = 8'd100;
  logic [CW-1:0] hyst = 8'd10;
  logic [CW-1:0] low  = 8'd70;
  logic          sw_en, probe, lp;

  int checks = 0;
  int errors = 0;
  int wd = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_ctl #(.CW(CW), .PERIOD(P), .PROBE_LEN(L), .SETTLE_LEN(S)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .comp_code_i(comp), .thr_code_i(thr),
    .hyst_code_i(hyst), .low_code_i(low), .sw_en_o(sw_en), .probe_o(probe), .lp_o(lp)
  );

  // reference model: mode plus absolute cycle stamp of the next probe start
  int cyc = 0;
  int mode = 0;      // 0 switching, 1 waiting, 2 probing, 3 settling
  int probe_at = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= 0; mode <= 0; probe_at <= 0;
    end else begin
      cyc <= cyc + 1;
      case (mode)
        0: if (int'(comp) + int'(hyst) < int'(thr)) begin
             mode <= 1; probe_at <= cyc + 1 + P;
           end
        1: if (cyc + 1 == probe_at) mode <= 2;
        2: if (cyc + 1 == probe_at + L) mode <= 3;
        default:
          if (cyc + 1 == probe_at + L + S) begin
            if (int'(comp) > int'(low)) mode <= 0;
            else begin mode <= 1; probe_at <= probe_at + P; end
          end
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(sw_en == (mode == 0), "R2/R6 model sw_en", int'(sw_en), int'(mode == 0));
      chk(probe == (mode == 2), "R4/R5 model probe", int'(probe), int'(mode == 2));
      chk(lp == (mode == 1), "R3/R7 model lp", int'(lp), int'(mode == 1));
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", wd);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int n;
    step(2);
    chk(sw_en && !probe && !lp, "R1 in reset", {sw_en, probe, lp}, 3'b100);
    rst_n = 1'b1;
    step(3);
    chk(sw_en && !probe && !lp, "R1 after reset", {sw_en, probe, lp}, 3'b100);

    // R2 equality boundary: 90+10 == 100 keeps switching
    comp = 8'd90;
    step(5);
    chk(sw_en == 1'b1, "R2 equality stays", int'(sw_en), 1);

    comp = 8'd89;
    step(1);
    chk(!sw_en && lp, "R2 entry", {sw_en, lp}, 2'b01);
    chk(lp && !probe, "R3 waiting flag", {probe, lp}, 2'b01);

    comp = 8'd70; // equal to low: must not resume
    n = 0;
    while (!probe) begin if (lp) n++; step(1); end
    chk(n == P, "R4 first probe delay", n, P);

    n = 0;
    while (probe) begin n++; step(1); end
    chk(n == L, "R5 probe width", n, L);
    n = 0;
    while (!sw_en && !lp && !probe) begin n++; step(1); end
    chk(n == S, "R5 settle length", n, S);
    chk(lp && !sw_en, "R7 stays asleep at equality", {sw_en, lp}, 2'b01);

    // R8: high code during the wait is ignored
    step(5);
    comp = 8'd200;
    step(3);
    chk(lp && !sw_en, "R8 wait ignores code", {sw_en, lp}, 2'b01);
    comp = 8'd50;
    n = 0;
    while (!probe) begin n++; step(1); end
    chk(n == P - L - S - 5 - 3, "R4 probe spacing", n, P - L - S - 8);

    // R8: high code during the probe and early settle, low at the sampling edge
    comp = 8'd200;
    while (probe) step(1);
    step(S - 1);
    comp = 8'd50;
    step(1);
    chk(lp && !sw_en, "R8 probe and settle ignored", {sw_en, lp}, 2'b01);

    // R6: code above low at sampling edge resumes
    while (!probe) step(1);
    comp = 8'd71;
    while (probe) step(1);
    n = 0;
    while (!sw_en && !lp) begin n++; step(1); end
    chk(n == S, "R6 resume timing", n, S);
    chk(sw_en == 1'b1, "R6 resumed", int'(sw_en), 1);

    // R9: hysteresis above threshold never enters, even at code zero
    thr = 8'd20; hyst = 8'd30; comp = 8'd0;
    step(60);
    chk(sw_en == 1'b1, "R9 no wrap entry", int'(sw_en), 1);

    // R9: live thresholds, top of range
    thr = 8'd255; hyst = 8'd200; comp = 8'd54; low = 8'd254;
    step(2);
    chk(lp == 1'b1, "R9 live threshold entry", int'(lp), 1);
    comp = 8'd255;
    n = 0;
    while (!sw_en && n < 2 * P) begin n++; step(1); end
    chk(sw_en == 1'b1, "R9 resume above live low", int'(sw_en), 1);
    comp = 8'd150; thr = 8'd100; hyst = 8'd10;
    step(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule